// File: doc/BRIEF.md
# Rate-Selectable Preset Counter Divider

This block derives a data-rate clock from a fast oscillator clock by integer division. A small up-counter is loaded with a starting value, called the precount, and counts up to its all-ones state. At all ones it raises a terminal pulse for one clock, and on the following edge it loads the precount again. The terminal pulse therefore repeats every (2^CNT_W − precount) oscillator cycles. A toggle stage fed by that pulse halves the rate and produces a square data clock with a 50 % duty cycle. The total division factor is 2 × (2^CNT_W − precount).

The divisor comes from a rate-select bus that is one-hot and active-low. Exactly one line is driven low, and the position of that line picks an entry from a parameter table of precounts. If no line is low, or more than one is low, the decoder falls back to a default precount and raises an error flag. The counter reads a new precount only when it reloads, so changing the rate never cuts an output period short.

Top module: `rate_divider`

## Requirements
- R1: After each load the counter holds the precount and then rises by one on every clock until it reaches all ones (4'b1111 at the default width).
- R2: `term_pulse` is high exactly while the count is all ones. For any precount below all ones, it is high for a single clock per count cycle.
- R3: On the edge after the terminal count the precount is loaded again, so `term_pulse` repeats every (16 − precount) clocks. For example, precount 8 gives a pulse every 8 clocks, seven counts after the load.
- R4: `data_clk` inverts on each edge that reloads the counter and changes on no other edge. It is therefore high for (16 − precount) clocks and low for (16 − precount) clocks, and the total division is 2 × (16 − precount).
- R5: `rate_sel_n` is active-low one-hot. When only bit i is 0, the precount is entry i of `PRECOUNTS`, a 4-bit binary value whose MSB is the highest-order bit of the field at bits [4i+3:4i]. With the default table, bits 0..7 select 8, 12, 14, 15, 0, 4, 10 and 13.
- R6: `sel_err` is 1 whenever the number of 0 bits on `rate_sel_n` is not exactly one, and in that case the precount is the default value 8. `sel_err` is 0 when exactly one bit is 0. The flag follows the input combinationally.
- R7: While `rst` is high on a clock edge, the counter loads the currently selected precount and `data_clk` is cleared to 0.
- R8: A change on `rate_sel_n` partway through a count cycle does not alter the current cycle. The new precount is used from the next reload onward.
- R9: Precount 15 keeps `term_pulse` high on every clock, and `data_clk` toggles on every edge, which divides by 2.
- R10: Precount 0 gives the longest cycle: a terminal pulse every 16 clocks and a data clock period of 32 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel_n | input | NUM_RATES | Active-low one-hot rate select |
| data_clk | output | 1 | Divided square data clock |
| term_pulse | output | 1 | One-clock terminal-count pulse |
| sel_err | output | 1 | Rate select is not exactly one-hot |

## Verification
The properties assume that `rate_sel_n` changes synchronously with `clk` and that `rst` is high from time zero until at least one edge has passed. Under those assumptions, every reload value, increment and toggle can be checked against the previous cycle. The stimulus changes the select bus and reset only at falling edges, and it holds reset high from the start. The mid-cycle rate change is made at a falling edge, so it cannot race a reload.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;

   typedef enum logic {
      SEL_OK  = 1'b0,
      SEL_BAD = 1'b1
   } sel_status_e;

   // Number of bits needed to count up to n inclusive
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rate_div_decoder.sv
module rate_div_decoder
   import rate_div_pkg::*;
#(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned NUM_RATES   = 8,
   parameter logic [NUM_RATES*CNT_W-1:0] PRECOUNTS = '0,
   parameter int unsigned DEFAULT_PRE = 8
) (
   input  logic [NUM_RATES-1:0] rate_sel_n,
   output logic [CNT_W-1:0]     precount_o,
   output logic                 sel_err_o
);

   localparam int unsigned SEL_W = cnt_bits(NUM_RATES);

   logic [NUM_RATES-1:0] hit;
   logic [CNT_W-1:0]     masked [NUM_RATES];
   logic [CNT_W-1:0]     merged;
   logic [SEL_W-1:0]     n_low;
   sel_status_e          status;

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
      assign hit[i]    = ~rate_sel_n[i];
      assign masked[i] = hit[i] ? PRECOUNTS[i*CNT_W +: CNT_W] : '0;
   end

   always_comb begin
      merged = '0;
      n_low  = '0;
      for (int j = 0; j < NUM_RATES; j++) begin
         merged = merged | masked[j];
         n_low  = n_low + SEL_W'(hit[j]);
      end
      status = (n_low == SEL_W'(1)) ? SEL_OK : SEL_BAD;
   end

   assign precount_o = (status == SEL_OK) ? merged : CNT_W'(DEFAULT_PRE);
   assign sel_err_o  = (status == SEL_BAD);

endmodule

// File: rtl/rate_div_counter.sv
module rate_div_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] precount_i,
   output logic [CNT_W-1:0] count_o,
   output logic             term_o
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic [CNT_W-1:0] count_q;
   logic             at_top;

   assign at_top = (count_q == ALL_ONES);

   always_ff @(posedge clk) begin
      if (rst || at_top) begin
         count_q <= precount_i;
      end else begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;
   assign term_o  = at_top;

endmodule

// File: rtl/rate_div_toggle.sv
module rate_div_toggle (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   output logic q_o
);

   logic q_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_q <= 1'b0;
      end else if (tick_i) begin
         q_q <= ~q_q;
      end
   end

   assign q_o = q_q;

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned NUM_RATES   = 8,
   parameter logic [NUM_RATES*CNT_W-1:0] PRECOUNTS = 32'hDA40_FEC8,
   parameter int unsigned DEFAULT_PRE = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_RATES-1:0] rate_sel_n,
   output logic                 data_clk,
   output logic                 term_pulse,
   output logic                 sel_err
);

   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   if (CNT_W < 2) begin : g_bad_width
      $error("rate_divider: CNT_W must be at least 2");
   end
   if (NUM_RATES < 1) begin : g_bad_rates
      $error("rate_divider: NUM_RATES must be at least 1");
   end
   if (DEFAULT_PRE > CNT_MAX) begin : g_bad_default
      $error("rate_divider: DEFAULT_PRE does not fit in CNT_W bits");
   end

   logic [CNT_W-1:0] pre_w;
   logic [CNT_W-1:0] cnt_w;
   logic             tc_w;

   rate_div_decoder #(
      .CNT_W       (CNT_W),
      .NUM_RATES   (NUM_RATES),
      .PRECOUNTS   (PRECOUNTS),
      .DEFAULT_PRE (DEFAULT_PRE)
   ) dec_i (
      .rate_sel_n (rate_sel_n),
      .precount_o (pre_w),
      .sel_err_o  (sel_err)
   );

   rate_div_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk        (clk),
      .rst        (rst),
      .precount_i (pre_w),
      .count_o    (cnt_w),
      .term_o     (tc_w)
   );

   rate_div_toggle tog_i (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tc_w),
      .q_o    (data_clk)
   );

   assign term_pulse = tc_w;

endmodule

// File: rtl/rate_divider_chk.sv
module rate_divider_chk #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned NUM_RATES   = 8,
   parameter int unsigned DEFAULT_PRE = 8
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_RATES-1:0] rate_sel_n,
   input logic [CNT_W-1:0]     precount,
   input logic [CNT_W-1:0]     cnt,
   input logic                 term_pulse,
   input logic                 data_clk,
   input logic                 sel_err
);

   assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
      !term_pulse |=> (cnt == $past(cnt) + 1'b1));

   assert_term_at_top_R2: assert property (@(posedge clk) disable iff (rst)
      term_pulse |-> (cnt == '1));

   assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
      term_pulse |=> (cnt == $past(precount)));

   assert_toggle_on_reload_R4: assert property (@(posedge clk) disable iff (rst)
      term_pulse |=> (data_clk != $past(data_clk)));

   assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
      !term_pulse |=> $stable(data_clk));

   assert_bad_select_R6: assert property (@(posedge clk) disable iff (rst)
      ($countones(~rate_sel_n) != 1) |-> (sel_err && precount == CNT_W'(DEFAULT_PRE)));

   assert_good_select_R6: assert property (@(posedge clk) disable iff (rst)
      ($countones(~rate_sel_n) == 1) |-> !sel_err);

   assert_reset_state_R7: assert property (@(posedge clk)
      rst |=> (data_clk == 1'b0 && cnt == $past(precount)));

endmodule

bind rate_divider rate_divider_chk #(
   .CNT_W       (CNT_W),
   .NUM_RATES   (NUM_RATES),
   .DEFAULT_PRE (DEFAULT_PRE)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .rate_sel_n (rate_sel_n),
   .precount   (pre_w),
   .cnt        (cnt_w),
   .term_pulse (term_pulse),
   .data_clk   (data_clk),
   .sel_err    (sel_err)
);

// File: tb/rate_divider_tb_top.sv
module rate_divider_tb_top;

   localparam int NV = 11;
   localparam logic [7:0] VEC_SEL [NV] = '{8'hFE, 8'hFD, 8'hFB, 8'hF7, 8'hEF, 8'hDF,
                                          8'hBF, 8'h7F, 8'hFF, 8'hFC, 8'h00};
   localparam int         VEC_PRE [NV] = '{8, 12, 14, 15, 0, 4, 10, 13, 8, 8, 8};
   localparam logic       VEC_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] rate_sel_n = 8'hFE;
   logic       data_clk, term_pulse, sel_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   rate_divider dut_i (
      .clk        (clk),
      .rst        (rst),
      .rate_sel_n (rate_sel_n),
      .data_clk   (data_clk),
      .term_pulse (term_pulse),
      .sel_err    (sel_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // Apply a select, pulse reset for one edge, leave inputs at the falling edge after it
   task automatic start(input logic [7:0] sel);
      @(negedge clk);
      rate_sel_n = sel;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // Reset state (R7)
      @(negedge clk);
      @(negedge clk);
      chk("R7 reset data_clk", data_clk, 0);
      chk("R6 reset sel_err", sel_err, 0);

      // Vector walk: R1 R2 R3 R4 R5 R6 R9 R10
      for (int v = 0; v < NV; v++) begin
         int len;
         int mis_tc;
         int mis_dc;
         len    = 16 - VEC_PRE[v];
         mis_tc = 0;
         mis_dc = 0;
         start(VEC_SEL[v]);
         chk("R6 sel_err", sel_err, VEC_ERR[v]);
         chk("R7 data_clk after reset", data_clk, 0);
         for (int k = 0; k < 4 * len + 2; k++) begin
            if (k != 0) @(negedge clk);
            if (term_pulse != ((k % len) == len - 1)) mis_tc++;
            if (data_clk != ((k / len) % 2 == 1)) mis_dc++;
         end
         // R2 R3 R5 R10: terminal pulse spacing follows the selected precount
         chk($sformatf("R3 R5 term_pulse pattern vec%0d", v), mis_tc, 0);
         // R4 R9: data clock halves the pulse rate with equal halves
         chk($sformatf("R4 data_clk pattern vec%0d", v), mis_dc, 0);
      end

      // R8: change select mid-cycle, 8 -> 0 applied after 3 counts
      start(8'hFE);
      for (int k = 0; k <= 24; k++) begin
         if (k != 0) @(negedge clk);
         if (k == 3) rate_sel_n = 8'hEF;
         chk($sformatf("R8 term_pulse k=%0d", k), term_pulse, (k == 7 || k == 23) ? 1 : 0);
         chk($sformatf("R8 data_clk k=%0d", k), data_clk, (k >= 8 && k <= 23) ? 1 : 0);
      end

      // R7: reset in the middle of a high data_clk phase
      start(8'hF7);
      @(negedge clk);
      chk("R9 toggled high", data_clk, 1);
      rst = 1'b1;
      rate_sel_n = 8'hFE;
      @(negedge clk);
      rst = 1'b0;
      chk("R7 mid-run reset data_clk", data_clk, 0);
      chk("R7 mid-run reset term_pulse", term_pulse, 0);
      repeat (7) @(negedge clk);
      chk("R1 seven counts to top", term_pulse, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule